// File: doc/BRIEF.md
# On-Screen Character Display Generator

This block lays a grid of characters over active video. It is a 10-row by 25-column text overlay. A host port fills a character buffer. The timing block supplies a pixel count and a line count. For every pixel the generator works out which character cell the pixel falls in and reads that cell's code from the buffer. It evaluates the glyph generated for that code at the pixel's dot position and classifies the pixel as one of four kinds: character, outline, opaque background or plain video.

The glyphs are made by a small arithmetic font, not stored artwork. Each glyph lies inside a box one dot larger on every side, and the outline is drawn in that extra margin. A downstream mixer uses the key flag to choose between overlay and video, and the colour index to pick the overlay colour. Results are registered, so every output reflects the inputs presented one clock earlier.

Top module: `osd_char_overlay`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it goes high, `ovl_key` is 0, `ovl_kind` is 0 and `ovl_color` is 0. After that, the outputs in a cycle reflect the inputs sampled at the previous rising clock edge.
- R2: When `osd_en` was 0 at the sampling edge, `ovl_kind` is 0 (plain video).
- R3: The overlay window covers pixel counts 176 up to 785 inclusive. In lines it covers 41 to 240 when `pal` is 0 and 47 to 286 when `pal` is 1. Any pixel outside the window gives kind 0.
- R4: Inside the window, hx = pixel-176 and vy = line-start. The cell is column hx/24 and row vy/20, and the in-cell position is lx = hx%24 and ly = vy%20. The cell's code is read from buffer address 32*row + column. A window pixel with column 25 or higher, or with row 10 or higher, is treated as background.
- R5: A host write with `wr_en` high stores `wr_data` at `wr_addr` only when the address is below 320 and its low five bits are below 25. All other writes are ignored. A pixel sampled on the same edge as a write still shows the old code, and the new code shows from the next sampled pixel onward.
- R6: The glyph dot at (gx, gy), with 0<=gx<12 and 0<=gy<14, sits at box position (lx, ly) = (gx+1, gy+1). The dot is lit when bit ((gx+2*gy) mod 8) of the code is 1. Code 0xAE (blank) and codes 0xFA to 0xFF light no dots.
- R7: A pixel is an outline pixel (kind 2) when it is not a lit dot and at least one of its eight neighbouring positions is a lit dot. Lit dots are kind 3.
- R8: A character pixel takes the colour index equal to `char_sel`: 0 white, 1 cyan, 2 green, 3 magenta.
- R9: Outline pixels take colour index 5 (black). A window pixel that is neither lit nor outline gives kind 0 when `back_sel[1]` is 0 (transparent). It gives kind 1 with colour 4 (blue) when `back_sel` is 2'b10, and kind 1 with colour 5 (black) when `back_sel` is 2'b11.
- R10: The kind codes are 0 video, 1 background, 2 outline and 3 character. `ovl_key` is 1 exactly when the kind is not 0. `ovl_color` is 0 whenever `ovl_key` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| pix_cnt | input | 10 | Horizontal pixel count from the timing block |
| line_cnt | input | 10 | Field line count from the timing block |
| pal | input | 1 | 1 selects the 50 Hz vertical window |
| osd_en | input | 1 | Overlay enable |
| char_sel | input | 2 | Character colour select |
| back_sel | input | 2 | Background select |
| wr_en | input | 1 | Host write strobe for the character buffer |
| wr_addr | input | 9 | Buffer address (row*32 + column) |
| wr_data | input | 8 | Character code to store |
| ovl_key | output | 1 | Overlay replaces video at this pixel |
| ovl_kind | output | 2 | Pixel classification |
| ovl_color | output | 3 | Overlay colour index |

## Verification
A host write and the display read of the same cell can land on the same clock edge. The bench provokes this by presenting a lit-dot pixel of a cell while rewriting that cell from a code that lights nothing to one that lights the dot. It expects background in that cycle and a character pixel in the next. The random phase also mixes writes in among the pixel samples, and the reference model is only updated after each sample has been compared, so any early or late update of the buffer is exposed.

// File: rtl/osd_char_overlay.sv
module osd_char_overlay #(
  parameter int H_START  = 176,
  parameter int H_END    = 786,
  parameter int V_LO_60  = 41,
  parameter int V_HI_60  = 241,
  parameter int V_LO_50  = 47,
  parameter int V_HI_50  = 287,
  parameter int COLS     = 25,
  parameter int ROWS     = 10,
  parameter int PITCH    = 32,
  parameter int CELL_W   = 24,
  parameter int CELL_H   = 20,
  parameter int GLYPH_W  = 12,
  parameter int GLYPH_H  = 14,
  parameter int NCODES   = 250,
  parameter logic [7:0] BLANK = 8'hAE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] pix_cnt,
  input  logic [9:0] line_cnt,
  input  logic       pal,
  input  logic       osd_en,
  input  logic [1:0] char_sel,
  input  logic [1:0] back_sel,
  input  logic       wr_en,
  input  logic [8:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       ovl_key,
  output logic [1:0] ovl_kind,
  output logic [2:0] ovl_color
);
  localparam int DEPTH = ROWS * PITCH;
  localparam int AW    = $clog2(DEPTH);

  localparam logic [1:0] K_VIDEO = 2'd0;
  localparam logic [1:0] K_BACK  = 2'd1;
  localparam logic [1:0] K_EDGE  = 2'd2;
  localparam logic [1:0] K_CHAR  = 2'd3;
  localparam logic [2:0] C_BLUE  = 3'd4;
  localparam logic [2:0] C_BLACK = 3'd5;

  logic [7:0] char_ram [DEPTH];

  logic wr_ok;
  assign wr_ok = wr_en && (int'(wr_addr) < DEPTH) && ((int'(wr_addr) % PITCH) < COLS);

  always_ff @(posedge clk)
    if (wr_ok) char_ram[wr_addr[AW-1:0]] <= wr_data;

  function automatic logic glyph_dot(input logic [7:0] c, input int bx, input int by);
    int gx, gy;
    gx = bx - 1;
    gy = by - 1;
    if (c == BLANK || int'(c) >= NCODES) return 1'b0;
    if (gx < 0 || gx >= GLYPH_W || gy < 0 || gy >= GLYPH_H) return 1'b0;
    return c[3'((gx + 2 * gy) % 8)];
  endfunction

  int hx, vy, col, row, lx, ly, v_lo, v_hi;
  logic in_win, in_grid, is_char, near_char;
  logic [7:0] code;
  logic [1:0] kind_d;
  logic [2:0] color_d;

  always_comb begin
    v_lo    = pal ? V_LO_50 : V_LO_60;
    v_hi    = pal ? V_HI_50 : V_HI_60;
    hx      = int'(pix_cnt) - H_START;
    vy      = int'(line_cnt) - v_lo;
    in_win  = osd_en && hx >= 0 && int'(pix_cnt) < H_END && vy >= 0 && int'(line_cnt) < v_hi;
    col     = in_win ? hx / CELL_W : COLS;
    row     = in_win ? vy / CELL_H : ROWS;
    lx      = in_win ? hx % CELL_W : 0;
    ly      = in_win ? vy % CELL_H : 0;
    in_grid = in_win && col < COLS && row < ROWS;
    code    = BLANK;
    if (in_grid) code = char_ram[AW'(row * PITCH + col)];
    is_char   = glyph_dot(code, lx, ly);
    near_char = 1'b0;
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        near_char = near_char | glyph_dot(code, lx + dx, ly + dy);
    kind_d  = K_VIDEO;
    color_d = 3'd0;
    if (in_win) begin
      if (is_char) begin
        kind_d  = K_CHAR;
        color_d = {1'b0, char_sel};
      end else if (near_char) begin
        kind_d  = K_EDGE;
        color_d = C_BLACK;
      end else if (back_sel[1]) begin
        kind_d  = K_BACK;
        color_d = back_sel[0] ? C_BLACK : C_BLUE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovl_kind  <= K_VIDEO;
      ovl_color <= 3'd0;
    end else begin
      ovl_kind  <= kind_d;
      ovl_color <= color_d;
    end

  assign ovl_key = (ovl_kind != K_VIDEO);

  // R2
  a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !osd_en |=> !ovl_key);
  // R3
  a_r3_outside_columns: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pix_cnt) < H_START || int'(pix_cnt) >= H_END) |=> !ovl_key);
  // R8
  a_r8_char_colour: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_kind == K_CHAR) |-> (ovl_color == {1'b0, $past(char_sel)}));
  // R9
  a_r9_edge_black: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_kind == K_EDGE) |-> (ovl_color == C_BLACK));
  a_r9_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    !back_sel[1] |=> (ovl_kind != K_BACK));
  // R10
  a_r10_idle_colour: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_key |-> (ovl_color == 3'd0));
endmodule

// File: tb/test_osd_char_overlay.sv
module test_osd_char_overlay;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pix_cnt = '0, line_cnt = '0;
  logic       pal = 1'b0, osd_en = 1'b0;
  logic [1:0] char_sel = 2'd0, back_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ovl_key;
  logic [1:0] ovl_kind;
  logic [2:0] ovl_color;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:319];

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_char_overlay i_osd_char_overlay (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .pal(pal),
    .osd_en(osd_en), .char_sel(char_sel), .back_sel(back_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ovl_key(ovl_key), .ovl_kind(ovl_kind),
    .ovl_color(ovl_color));

  function automatic logic lit(input logic [7:0] c, input int bx, input int by);
    int gx, gy;
    gx = bx - 1; gy = by - 1;
    if (c == 8'hAE || c >= 8'hFA) return 1'b0;
    if (gx < 0 || gx > 11 || gy < 0 || gy > 13) return 1'b0;
    return c[(gx + 2 * gy) % 8];
  endfunction

  function automatic void expect_px(input int p, input int l, output logic [1:0] k, output logic [2:0] c);
    int vs, ve, col, row, lx, ly;
    logic [7:0] code;
    logic e;
    vs = pal ? 47 : 41; ve = pal ? 287 : 241;
    k = 2'd0; c = 3'd0;
    if (!osd_en || p < 176 || p >= 786 || l < vs || l >= ve) return;
    col = (p - 176) / 24; lx = (p - 176) % 24;
    row = (l - vs) / 20;  ly = (l - vs) % 20;
    code = (col < 25 && row < 10) ? mem[row * 32 + col] : 8'hAE;
    e = 1'b0;
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        if (lit(code, lx + dx, ly + dy)) e = 1'b1;
    if (lit(code, lx, ly)) begin k = 2'd3; c = {1'b0, char_sel}; end
    else if (e) begin k = 2'd2; c = 3'd5; end
    else if (back_sel[1]) begin k = 2'd1; c = back_sel[0] ? 3'd5 : 3'd4; end
  endfunction

  task automatic check(input string tag, input logic [1:0] ek, input logic [2:0] ec);
    checks++;
    if (ovl_kind !== ek || ovl_color !== ec || ovl_key !== (ek != 2'd0)) begin
      errors++;
      $display("FAIL %s: kind=%0d color=%0d key=%0d expected kind=%0d color=%0d key=%0d",
               tag, ovl_kind, ovl_color, ovl_key, ek, ec, (ek != 2'd0));
    end
  endtask

  // one pixel sample, optionally with a host write on the same edge
  task automatic cyc(input string tag, input int p, input int l,
                     input logic we = 1'b0, input int wa = 0, input int wd = 0);
    logic [1:0] ek;
    logic [2:0] ec;
    @(negedge clk);
    pix_cnt = 10'(p); line_cnt = 10'(l);
    wr_en = we; wr_addr = 9'(wa); wr_data = 8'(wd);
    expect_px(p, l, ek, ec);
    @(posedge clk); #1;
    if (we && wa < 320 && (wa % 32) < 25) mem[wa] = 8'(wd);
    wr_en = 1'b0;
    check(tag, ek, ec);
  endtask

  task automatic cfg(input logic en, input logic pl, input logic [1:0] cs, input logic [1:0] bs);
    @(negedge clk);
    osd_en = en; pal = pl; char_sel = cs; back_sel = bs;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 320; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1 check("R1 in reset", 2'd0, 3'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release", 2'd0, 3'd0);

    // fill buffer with the overlay off (R2, R5)
    for (int r = 0; r < 10; r++)
      for (int c = 0; c < 25; c++) begin
        int code;
        code = (c == 24) ? 8'hAE : int'($urandom_range(0, 249));
        if (r == 0 && c == 0) code = 8'h01;
        if (r == 0 && c == 1) code = 8'hFF;
        if (r == 0 && c == 2) code = 8'hAE;
        if (r == 0 && c == 3) code = 8'h00;
        if (r == 2 && c == 0) code = 8'h00;
        cyc("R2 disabled", 176 + c * 24 + 2, 43 + r * 20, 1'b1, r * 32 + c, code);
      end

    cfg(1'b1, 1'b0, 2'd0, 2'b10);
    // R3 window edges
    cyc("R3 left-out", 175, 50);  cyc("R3 left-in", 176, 50);
    cyc("R3 right-in", 785, 50);  cyc("R3 right-out", 786, 50);
    cyc("R3 top-out", 300, 40);   cyc("R3 top-in", 300, 41);
    cyc("R3 bot-in", 300, 240);   cyc("R3 bot-out", 300, 241);
    cfg(1'b1, 1'b1, 2'd0, 2'b10);
    cyc("R3 pal top-out", 300, 46);  cyc("R3 pal top-in", 300, 47);
    cyc("R3 pal bot-in", 300, 286);  cyc("R3 pal bot-out", 300, 287);
    cyc("R4 pal row10 background", 300, 260);
    cfg(1'b1, 1'b0, 2'd0, 2'b10);
    cyc("R4 column25 background", 780, 50);

    // R6/R7 on the 0x01 cell at row0 col0
    cyc("R6 lit dot", 177, 42);
    cyc("R7 outline corner", 176, 41);
    cyc("R7 outline right", 178, 42);
    cyc("R6 unlit interior", 179, 42);
    for (int y = 0; y < 18; y++)
      for (int x = 0; x < 16; x++) cyc("R7 cell scan", 176 + x, 41 + y);
    cyc("R6 code 0xFF blank", 176 + 24 + 5, 46);
    cyc("R6 code 0xAE blank", 176 + 48 + 5, 46);

    // R8 colours
    for (int s = 0; s < 4; s++) begin
      cfg(1'b1, 1'b0, 2'(s), 2'b10);
      cyc("R8 char colour", 177, 42);
    end
    cfg(1'b1, 1'b0, 2'd0, 2'b00);
    cyc("R9 transparent", 179, 42);
    cyc("R9 edge transparent bg", 176, 41);
    cfg(1'b1, 1'b0, 2'd0, 2'b01);
    cyc("R9 transparent 01", 179, 42);
    cfg(1'b1, 1'b0, 2'd0, 2'b11);
    cyc("R9 black", 179, 42);
    cfg(1'b1, 1'b0, 2'd0, 2'b10);
    cyc("R9 blue", 179, 42);

    // R5 ignored addresses
    cyc("R5 ignored col25", 300, 30, 1'b1, 9'h019, 8'h01);
    cyc("R5 ignored row10", 300, 30, 1'b1, 9'h140, 8'h01);
    cyc("R5 ignored high", 300, 30, 1'b1, 9'h1C0, 8'h01);
    for (int y = 0; y < 18; y++)
      for (int x = 0; x < 16; x++) begin
        cyc("R5 row2 col0 unchanged", 176 + x, 81 + y);
        cyc("R5 row0 col24 unchanged", 176 + 576 + x, 41 + y);
      end

    // R5 same-edge write and read of one cell (row0 col3: 0x00 -> 0x01)
    cyc("R5 same-edge old code", 176 + 72 + 1, 42, 1'b1, 3, 8'h01);
    cyc("R5 next cycle new code", 176 + 72 + 1, 42);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0)
        cfg(($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 7) == 0)
        cyc("R4 random with write", $urandom_range(150, 800), $urandom_range(30, 300),
            1'b1, $urandom_range(0, 511), $urandom_range(0, 255));
      else
        cyc("R4 random", $urandom_range(150, 800), $urandom_range(30, 300));
    end

    cfg(1'b0, 1'b0, 2'd0, 2'b11);
    cyc("R2 disabled again", 177, 42);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule